// File: doc/BRIEF.md
# SCSI Controller Command Sequencer

This block is the command front end of a SCSI host controller. A host strobes in a 7-bit command code. The sequencer decodes it and takes the immediate side effects in the cycle of the strobe. For most commands it then arms a completion timer. When the timer expires, the block posts an 8-bit completion code into its status register, updates its auxiliary status flags and raises an interrupt. The host then acknowledges the interrupt. A small configuration port loads the three values the commands depend on: an advanced-features flag, a destination target ID and a 24-bit transfer count.

A `target_present` mask stands in for bus arbitration and selection: bit N high means target N answers a selection. A successful selection arms a second, longer timer. When that timer expires, the block raises a service-request interrupt whose status carries the next bus phase. Both delays are parameters counted in clock cycles.

Top module: `scsi_cmd_sequencer`

## Requirements
- R1: When `rst_n` is low at a clock edge, `scsi_status`, `aux_status` and `bus_phase` become zero and `irq` becomes low.
- R2: Configuration writes use the following `cfg_addr` values. Address 0 stores `cfg_wdata[3]` as the advanced-features flag. Address 1 stores `cfg_wdata[2:0]` as the destination ID. Addresses 2, 3 and 4 store the low, middle and high bytes of the 24-bit transfer count.
- R3: For every command except codes 0x03 and 0x04, `aux_status[4]` (command in progress) is high in the cycle after the strobe. The completion is posted exactly DONE_DLY cycles after the strobe edge. Posting writes the code to `scsi_status`, sets `aux_status[7]`, clears `aux_status[5:4]` and raises `irq`.
- R4: At a posting, `aux_status[0]` is set if the transfer count is nonzero and cleared otherwise.
- R5: Code 0x00 clears the flag, the destination ID, the transfer count, `scsi_status`, `bus_phase`, `irq` and the other auxiliary bits. It completes with 0x01 if the advanced-features flag was set before the command, and with 0x00 otherwise.
- R6: Code 0x01 (abort) completes with 0x28. Every code not listed in R5 to R9 completes with 0x40.
- R7: Codes 0x03 (negate ACK) and 0x04 (disconnect) clear `aux_status[5:4]` in the next cycle. They post no status and leave `scsi_status` and `irq` unchanged.
- R8: Codes 0x06 (select with ATN) and 0x07 (select) set `aux_status[5]` (busy) in the next cycle. The select completes with 0x11 if `target_present` has the bit of the destination ID set, and with 0x42 otherwise.
- R9: A successful select sets `bus_phase` to 6 for code 0x06 and to 2 for code 0x07. Exactly SVC_DLY cycles after the strobe, the block posts 0x88 OR `bus_phase` in the manner of R3.
- R10: A `status_ack` pulse clears `irq` and `aux_status[7]` at the next edge. If a posting occurs at the same edge, the posting wins and `irq` stays high.
- R11: A new command strobe cancels any pending completion and any pending service request; only the newer command's results appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 7 | Command code |
| target_present | input | 8 | Per-ID target response mask |
| status_ack | input | 1 | Interrupt acknowledge (status read) |
| scsi_status | output | 8 | Last posted completion code |
| aux_status | output | 8 | Flags: 7 interrupt, 5 busy, 4 in progress, 0 buffer ready |
| irq | output | 1 | Interrupt request |
| bus_phase | output | 3 | Current bus phase |

## Verification
A timer that is armed wrongly or never cancelled shows up at the ports. Either `irq` rises at the wrong cycle, or a stale completion code replaces the newer one at the old deadline, which is at most DONE_DLY or SVC_DLY cycles after the strobe. A decode fault shows in `scsi_status` or `bus_phase` at the first posting. A fault in the flag logic shows in `aux_status` either in the cycle after the strobe or at the posting. A register that the reset command failed to clear shows on the next reset or select command, through the code it posts and through buffer-ready.

// File: rtl/cmdseq_pkg.sv
// Package: shared command codes, status codes, bus phases and the decoded
// action type for the command sequencer. Assumes 7-bit command codes.
package cmdseq_pkg;

    localparam logic [6:0] OP_RESET      = 7'h00;
    localparam logic [6:0] OP_ABORT      = 7'h01;
    localparam logic [6:0] OP_NEGATE_ACK = 7'h03;
    localparam logic [6:0] OP_DISCONNECT = 7'h04;
    localparam logic [6:0] OP_SELECT_ATN = 7'h06;
    localparam logic [6:0] OP_SELECT     = 7'h07;

    localparam logic [7:0] ST_RESET      = 8'h00;
    localparam logic [7:0] ST_RESET_ADV  = 8'h01;
    localparam logic [7:0] ST_SELECTED   = 8'h11;
    localparam logic [7:0] ST_ABORTED    = 8'h28;
    localparam logic [7:0] ST_BAD_CMD    = 8'h40;
    localparam logic [7:0] ST_NO_TARGET  = 8'h42;
    localparam logic [7:0] ST_SERVICE    = 8'h88;

    localparam logic [2:0] PH_COMMAND = 3'd2;
    localparam logic [2:0] PH_MSG_OUT = 3'd6;

    localparam int AUX_INT  = 7;
    localparam int AUX_BUSY = 5;
    localparam int AUX_CIP  = 4;
    localparam int AUX_DBR  = 0;

    typedef enum logic [1:0] {
        ACT_TIMED   = 2'd0,
        ACT_RELEASE = 2'd1,
        ACT_SELECT  = 2'd2,
        ACT_CLEAR   = 2'd3
    } cmd_action_e;

endpackage

// File: rtl/cmdseq_decode.sv
// Command decoder: maps a command code to an action class, the completion
// code to post later and, for selects, the next bus phase. Purely combinational;
// assumes the caller supplies the current advanced flag and target response.
module cmdseq_decode
    import cmdseq_pkg::*;
(
    input  logic [6:0]  code,
    input  logic        adv_flag,
    input  logic        tgt_hit,
    output cmd_action_e action,
    output logic [7:0]  done_code,
    output logic [2:0]  next_phase
);

    // Classify the command and choose its completion code.
    always_comb begin
        action     = ACT_TIMED;
        done_code  = ST_BAD_CMD;
        next_phase = PH_COMMAND;
        case (code)
            OP_RESET: begin
                action    = ACT_CLEAR;
                done_code = adv_flag ? ST_RESET_ADV : ST_RESET;
            end
            OP_ABORT: begin
                done_code = ST_ABORTED;
            end
            OP_NEGATE_ACK, OP_DISCONNECT: begin
                action    = ACT_RELEASE;
                done_code = ST_RESET;
            end
            OP_SELECT_ATN, OP_SELECT: begin
                action     = ACT_SELECT;
                done_code  = tgt_hit ? ST_SELECTED : ST_NO_TARGET;
                next_phase = (code == OP_SELECT_ATN) ? PH_MSG_OUT : PH_COMMAND;
            end
            default: begin
                done_code = ST_BAD_CMD;
            end
        endcase
    end

endmodule

// File: rtl/cmdseq_delay.sv
// One-shot delay timer: arming loads DELAY, and fire is high during the
// cycle before the DELAY-th edge after arming. Cancel drops a pending shot.
// Assumes DELAY >= 1; arming takes priority over cancel.
module cmdseq_delay #(
    parameter int unsigned DELAY = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic cancel,
    output logic fire
);

    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] remain;
    logic          active;

    // Expiry: the last counted cycle of an armed shot.
    assign fire = active && (remain == CW'(1));

    // Countdown with arm, cancel and expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            remain <= '0;
        end else if (arm) begin
            active <= 1'b1;
            remain <= CW'(DELAY);
        end else if (cancel || fire) begin
            active <= 1'b0;
        end else if (active) begin
            remain <= remain - CW'(1);
        end
    end

endmodule

// File: rtl/cmdseq_regs.sv
// Configuration store: advanced flag, destination ID and a byte-written
// transfer count. A clear request wipes all of them and wins over a write.
module cmdseq_regs #(
    parameter int ID_W      = 3,
    parameter int CNT_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [2:0]             addr,
    input  logic [7:0]             wdata,
    input  logic                   clear,
    output logic                   adv_flag,
    output logic [ID_W-1:0]        dest_id,
    output logic [8*CNT_BYTES-1:0] xfer_cnt
);

    localparam logic [2:0] A_FLAG = 3'd0;
    localparam logic [2:0] A_DEST = 3'd1;
    localparam int         A_CNT0 = 2;

    // Flag and destination registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            adv_flag <= 1'b0;
            dest_id  <= '0;
        end else if (we) begin
            if (addr == A_FLAG) adv_flag <= wdata[3];
            if (addr == A_DEST) dest_id  <= wdata[ID_W-1:0];
        end
    end

    // One byte lane of the transfer count per generate step.
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                xfer_cnt[8*b +: 8] <= 8'h00;
            end else if (we && (addr == 3'(A_CNT0 + b))) begin
                xfer_cnt[8*b +: 8] <= wdata;
            end
        end
    end

endmodule

// File: rtl/scsi_cmd_sequencer.sv
// Command sequencer top: decodes strobed commands, applies their immediate
// effects, and posts delayed completion and service-request status with an
// interrupt. Assumes SVC_DLY > DONE_DLY >= 1 and one-cycle command strobes.
module scsi_cmd_sequencer
    import cmdseq_pkg::*;
#(
    parameter int unsigned DONE_DLY = 125,
    parameter int unsigned SVC_DLY  = 6250,
    parameter int          ID_W     = 3,
    parameter int          CNT_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [2:0]             cfg_addr,
    input  logic [7:0]             cfg_wdata,
    input  logic                   cmd_valid,
    input  logic [6:0]             cmd_code,
    input  logic [(1<<ID_W)-1:0]   target_present,
    input  logic                   status_ack,
    output logic [7:0]             scsi_status,
    output logic [7:0]             aux_status,
    output logic                   irq,
    output logic [2:0]             bus_phase
);

    localparam int CNT_W = 8 * CNT_BYTES;

    cmd_action_e       action;
    logic [7:0]        dec_code;
    logic [2:0]        dec_phase;
    logic [7:0]        pend_code;
    logic              adv_flag;
    logic [ID_W-1:0]   dest_id;
    logic [CNT_W-1:0]  xfer_cnt;
    logic              tgt_hit;
    logic              done_fire;
    logic              svc_fire;
    logic              arm_done;
    logic              arm_svc;
    logic              post_now;
    logic [7:0]        post_code;

    assign tgt_hit = target_present[dest_id];

    cmdseq_regs #(.ID_W(ID_W), .CNT_BYTES(CNT_BYTES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .clear    (cmd_valid && (action == ACT_CLEAR)),
        .adv_flag (adv_flag),
        .dest_id  (dest_id),
        .xfer_cnt (xfer_cnt)
    );

    cmdseq_decode u_dec (
        .code       (cmd_code),
        .adv_flag   (adv_flag),
        .tgt_hit    (tgt_hit),
        .action     (action),
        .done_code  (dec_code),
        .next_phase (dec_phase)
    );

    // Timers are armed by every command except the bus-release pair.
    assign arm_done = cmd_valid && (action != ACT_RELEASE);
    assign arm_svc  = cmd_valid && (action == ACT_SELECT) && tgt_hit;

    cmdseq_delay #(.DELAY(DONE_DLY)) u_done_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_done),
        .cancel (cmd_valid),
        .fire   (done_fire)
    );

    cmdseq_delay #(.DELAY(SVC_DLY)) u_svc_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_svc),
        .cancel (cmd_valid),
        .fire   (svc_fire)
    );

    // A posting happens on timer expiry unless a new command supersedes it.
    assign post_now  = !cmd_valid && (done_fire || svc_fire);
    assign post_code = done_fire ? pend_code : (ST_SERVICE | {5'b0, bus_phase});

    // Status, flags, phase and interrupt state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scsi_status <= 8'h00;
            aux_status  <= 8'h00;
            irq         <= 1'b0;
            bus_phase   <= 3'd0;
            pend_code   <= 8'h00;
        end else begin
            if (status_ack && !post_now) begin
                aux_status[AUX_INT] <= 1'b0;
                irq                 <= 1'b0;
            end
            if (cmd_valid) begin
                case (action)
                    ACT_CLEAR: begin
                        scsi_status <= 8'h00;
                        aux_status  <= 8'h00;
                        aux_status[AUX_CIP] <= 1'b1;
                        irq         <= 1'b0;
                        bus_phase   <= 3'd0;
                        pend_code   <= dec_code;
                    end
                    ACT_RELEASE: begin
                        aux_status[AUX_BUSY] <= 1'b0;
                        aux_status[AUX_CIP]  <= 1'b0;
                    end
                    ACT_SELECT: begin
                        aux_status[AUX_BUSY] <= 1'b1;
                        aux_status[AUX_CIP]  <= 1'b1;
                        pend_code            <= dec_code;
                        if (tgt_hit) bus_phase <= dec_phase;
                    end
                    default: begin
                        aux_status[AUX_CIP] <= 1'b1;
                        pend_code           <= dec_code;
                    end
                endcase
            end else if (post_now) begin
                scsi_status          <= post_code;
                aux_status[AUX_INT]  <= 1'b1;
                aux_status[AUX_BUSY] <= 1'b0;
                aux_status[AUX_CIP]  <= 1'b0;
                aux_status[AUX_DBR]  <= |xfer_cnt;
                irq                  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmdseq_checker.sv
// Checker: temporal properties of the command sequencer, bound to the top.
module cmdseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [6:0] cmd_code,
    input logic       status_ack,
    input logic       post_now,
    input logic [7:0] scsi_status,
    input logic [7:0] aux_status,
    input logic       irq,
    input logic [2:0] bus_phase
);

    logic is_release;
    assign is_release = (cmd_code == 7'h03) || (cmd_code == 7'h04);

    AST_CIP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !is_release |=> aux_status[4]);                        // R3

    AST_POST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> aux_status[7] && !aux_status[5] && !aux_status[4]);  // R3

    AST_IRQ_FROM_POST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(post_now));                                    // R3

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && is_release |=> !aux_status[5] && !aux_status[4]);      // R7

    AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && is_release |=> !$rose(irq) && $stable(scsi_status));   // R7

    AST_SVC_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && scsi_status[7] |-> scsi_status[2:0] == bus_phase);    // R9

    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        status_ack && !post_now && !cmd_valid |=> !irq);                    // R10

endmodule

bind scsi_cmd_sequencer cmdseq_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .status_ack  (status_ack),
    .post_now    (post_now),
    .scsi_status (scsi_status),
    .aux_status  (aux_status),
    .irq         (irq),
    .bus_phase   (bus_phase)
);

// File: tb/tb_scsi_cmd_sequencer.sv
module tb_scsi_cmd_sequencer;

    localparam int D = 8;
    localparam int S = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       cmd_valid = 1'b0;
    logic [6:0] cmd_code = '0;
    logic [7:0] target_present = '0;
    logic       status_ack = 1'b0;
    logic [7:0] scsi_status;
    logic [7:0] aux_status;
    logic       irq;
    logic [2:0] bus_phase;

    int total = 0;
    int bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    scsi_cmd_sequencer #(.DONE_DLY(D), .SVC_DLY(S)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .target_present(target_present), .status_ack(status_ack),
        .scsi_status(scsi_status), .aux_status(aux_status), .irq(irq),
        .bus_phase(bus_phase)
    );

    // {flag byte, dest, count[23:0], present mask, code(8b), exp status, exp buffer-ready}
    localparam int NV = 10;
    localparam logic [64:0] VEC [NV] = '{
        {8'h00, 8'h00, 24'h000005, 8'h00, 8'h01, 8'h28, 1'b1},  // R6 abort, R4 nonzero
        {8'h00, 8'h00, 24'h000000, 8'h00, 8'h01, 8'h28, 1'b0},  // R4 zero count
        {8'h00, 8'h00, 24'h000100, 8'h00, 8'h02, 8'h40, 1'b1},  // R6 unimplemented
        {8'h00, 8'h00, 24'h000000, 8'h00, 8'h7F, 8'h40, 1'b0},  // R6 invalid
        {8'h00, 8'h00, 24'h000000, 8'h00, 8'h45, 8'h40, 1'b0},  // R6 invalid
        {8'h00, 8'h03, 24'h010000, 8'h08, 8'h07, 8'h11, 1'b1},  // R8 hit, R2 high byte
        {8'h00, 8'h05, 24'h000000, 8'h08, 8'h06, 8'h42, 1'b0},  // R8 miss
        {8'h00, 8'h0D, 24'h000000, 8'h20, 8'h06, 8'h11, 1'b0},  // R8 low 3 bits, R2
        {8'h08, 8'h00, 24'h000003, 8'h00, 8'h00, 8'h01, 1'b0},  // R5 advanced
        {8'hF7, 8'h00, 24'h000003, 8'h00, 8'h00, 8'h00, 1'b0}   // R5 plain
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input logic [6:0] c);
        cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ack();
        status_ack = 1'b1;
        @(negedge clk);
        status_ack = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", scsi_status, 8'h00);
        chk("R1 aux", aux_status, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 phase", bus_phase, 3'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [64:0] v;
            v = VEC[i];
            wr(3'd0, v[64:57]);
            wr(3'd1, v[56:49]);
            wr(3'd2, v[32:25]);
            wr(3'd3, v[40:33]);
            wr(3'd4, v[48:41]);
            target_present = v[24:17];
            strobe(v[15:9]);
            chk("R3 cip set", aux_status[4], 1'b1);
            wait_n(D - 1);
            chk("R3 not early", irq, 1'b0);
            wait_n(1);
            chk("R3 irq", irq, 1'b1);
            chk("R3 R5 R6 R8 status", scsi_status, v[8:1]);
            chk("R3 flags", {aux_status[7], aux_status[5:4]}, 3'b100);
            chk("R4 dbr", aux_status[0], v[0]);
            ack();
            chk("R10 ack", {irq, aux_status[7]}, 2'b00);
        end

        // R9: select with ATN, then service request carrying message-out phase
        wr(3'd1, 8'h02); target_present = 8'h04;
        strobe(7'h06);
        chk("R8 busy", aux_status[5], 1'b1);
        wait_n(D);
        chk("R9 sel status", scsi_status, 8'h11);
        chk("R9 phase atn", bus_phase, 3'd6);
        ack();
        wait_n(S - D - 2);
        chk("R9 svc not early", irq, 1'b0);
        wait_n(1);
        chk("R9 svc irq", irq, 1'b1);
        chk("R9 svc status", scsi_status, 8'h8E);
        ack();
        strobe(7'h07);
        wait_n(D);
        chk("R9 phase cmd", bus_phase, 3'd2);
        ack();
        wait_n(S - D - 1);
        chk("R9 svc cmd status", scsi_status, 8'h8A);
        ack();

        // R7: disconnect cancels a pending select, no posting
        wr(3'd1, 8'h01); target_present = 8'h02;
        keep = scsi_status;
        strobe(7'h07);
        strobe(7'h04);
        chk("R7 disc flags", aux_status[5:4], 2'b00);
        wait_n(S + 2);
        chk("R7 R11 disc irq", irq, 1'b0);
        chk("R7 disc status", scsi_status, keep);
        strobe(7'h01);
        strobe(7'h03);
        chk("R7 nack flags", aux_status[5:4], 2'b00);
        wait_n(D + 2);
        chk("R7 nack irq", irq, 1'b0);
        chk("R7 nack status", scsi_status, keep);

        // R11: later command replaces an earlier pending one
        strobe(7'h01);
        wait_n(2);
        strobe(7'h02);
        wait_n(D - 4);
        wait_n(1);
        chk("R11 old deadline", irq, 1'b0);
        wait_n(2);
        chk("R11 not early", irq, 1'b0);
        wait_n(1);
        chk("R11 irq", irq, 1'b1);
        chk("R11 status", scsi_status, 8'h40);
        ack();

        // R10: acknowledge at the posting edge loses to the posting
        strobe(7'h01);
        wait_n(D - 1);
        ack();
        chk("R10 collision", irq, 1'b1);
        ack();
        chk("R10 cleared", irq, 1'b0);

        // R5: reset command clears configuration
        wr(3'd0, 8'h08); wr(3'd1, 8'h03); wr(3'd2, 8'h07);
        strobe(7'h00);
        wait_n(D);
        chk("R5 adv", scsi_status, 8'h01);
        ack();
        strobe(7'h00);
        wait_n(D);
        chk("R5 flag cleared", scsi_status, 8'h00);
        chk("R5 count cleared", aux_status[0], 1'b0);
        ack();
        target_present = 8'h01;
        strobe(7'h07);
        wait_n(D);
        chk("R5 dest cleared", scsi_status, 8'h11);
        ack();
        strobe(7'h04);

        // R1: reset mid-run
        strobe(7'h01);
        wait_n(D);
        rst_n = 1'b0;
        wait_n(1);
        rst_n = 1'b1;
        chk("R1 mid reset", {irq, aux_status, scsi_status}, 17'h0);
        finish_run();
    end

endmodule